// File: doc/BRIEF.md
# Masked Priority Interrupt-Level Encoder

This block gathers thirteen level-sensitive interrupt lines from board peripherals. It reduces them to a single 4-bit interrupt level for a processor. Each line owns a fixed bit in a 16-bit monitor word and a fixed priority code. Software enables lines through a mask register that uses the same bit layout. Among the lines that are both high and enabled, the lowest priority code wins. The encoder drives that code XOR 15, so a code of 0 gives level 15 and an idle system gives level 0.

The same small 16-bit register window holds three more registers. A general output-port register drives a board-level output bus. A version register is read-only. A power-off control raises a one-cycle shutdown request. The window decodes 6 address bits, which is a 64-byte span, and works only in 16-bit units.

Top module: `intlvl_top`

## Requirements
- R1: While rst_ni is low and after it is released, the mask and output-port registers hold 0, lvl_o is 0, off_req_o is 0 and rd_data_o is 0.
- R2: Input irq_i[k] has priority code k. Its monitor and mask bit position is fixed by the table k:bit = 0:11, 1:9, 2:8, 3:12, 4:10, 5:6, 6:5, 7:4, 8:7, 9:14, 10:13, 11:0, 12:15. Mask bits 1, 2 and 3 enable no input.
- R3: lvl_o equals 15 XOR the smallest k for which irq_i[k] is high and its mask bit is 1. It is 0 when no input qualifies.
- R4: lvl_o is registered. Each rising edge loads it from irq_i as sampled at that edge and from the mask value held before that edge. A mask write therefore changes lvl_o one edge after the write edge.
- R5: The mask register is at byte offset 0x00. It stores all 16 bits written and reads back the same value.
- R6: The output-port register is at offset 0x36. It stores all 16 bits written, reads back the same value, and drives port_o from the edge of the write.
- R7: Offset 0x32 always reads 0x0010, and writes to it change nothing.
- R8: Offset 0x30 reads 0. A write there with wr_data_i[0] = 1 sets off_req_o high for exactly the cycle after the write edge. A write with bit 0 = 0 produces no pulse.
- R9: A read strobed at an edge puts its data on rd_data_o from that edge until the next read. Reads of any other offset, odd offsets included, return 0, and writes to them change no register.
- R10: When a read and a write to the same register occur in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 13 | Interrupt lines; index k has priority code k |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Byte offset in the register window |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data, registered |
| lvl_o | output | 4 | Encoded interrupt level, 0 when idle |
| port_o | output | 16 | Output-port register contents |
| off_req_o | output | 1 | One-cycle shutdown request |

## Verification
The interesting collision is a mask write that lands in the same cycle as a change on the interrupt lines. The bench provokes it with a directed pattern and then many random cycles in which both move together. It judges each edge against a behavioural model in which the new line values apply at once and the new mask applies one edge later. A second collision is a read and a write to the mask or port register in the same cycle. There the model expects the pre-write value on the read bus and the new value on the following read.

// File: rtl/intlvl_pkg.sv
package intlvl_pkg;
  localparam int SRC_N   = 13;
  localparam int WORD_W  = 16;
  localparam int LEVEL_W = 4;
  localparam int ADR_W   = 6;

  localparam logic [ADR_W-1:0] OFS_MASK = 6'h00;
  localparam logic [ADR_W-1:0] OFS_OFF  = 6'h30;
  localparam logic [ADR_W-1:0] OFS_VER  = 6'h32;
  localparam logic [ADR_W-1:0] OFS_PORT = 6'h36;

  localparam logic [WORD_W-1:0] VERSION_ID = 16'h0010;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_OFF,
    SEL_VER,
    SEL_PORT
  } reg_sel_e;

  // monitor/mask bit owned by the source with priority code k
  function automatic int src_bit(input int k);
    case (k)
      0:  return 11;
      1:  return 9;
      2:  return 8;
      3:  return 12;
      4:  return 10;
      5:  return 6;
      6:  return 5;
      7:  return 4;
      8:  return 7;
      9:  return 14;
      10: return 13;
      11: return 0;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/intlvl_decode.sv
module intlvl_decode
  import intlvl_pkg::*;
(
  input  logic [ADR_W-1:0] addr_i,
  output reg_sel_e         sel_o
);
  always_comb begin
    unique case (addr_i)
      OFS_MASK: sel_o = SEL_MASK;
      OFS_OFF:  sel_o = SEL_OFF;
      OFS_VER:  sel_o = SEL_VER;
      OFS_PORT: sel_o = SEL_PORT;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/intlvl_regs.sv
module intlvl_regs
  import intlvl_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] port_o,
  output logic              off_req_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mask_q, port_q, rd_q, rd_mux;
  logic              off_q;

  always_comb begin
    unique case (sel_i)
      SEL_MASK: rd_mux = mask_q;
      SEL_PORT: rd_mux = port_q;
      SEL_VER:  rd_mux = DATA_W'(VERSION_ID);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      port_q <= '0;
      off_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      off_q <= wr_en_i && (sel_i == SEL_OFF) && wr_data_i[0];
      if (wr_en_i && sel_i == SEL_MASK) mask_q <= wr_data_i;
      if (wr_en_i && sel_i == SEL_PORT) port_q <= wr_data_i;
      // read sees pre-write state
      if (rd_en_i) rd_q <= rd_mux;
    end
  end

  assign mask_o    = mask_q;
  assign port_o    = port_q;
  assign off_req_o = off_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/intlvl_srcmap.sv
module intlvl_srcmap
  import intlvl_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int DATA_W  = WORD_W
) (
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic [DATA_W-1:0]  mask_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [DATA_W-1:0] mon;

  always_comb begin
    mon = '0;
    for (int k = 0; k < NUM_SRC; k++) mon[src_bit(k)] = irq_i[k];
  end

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_pend
    assign pend_o[k] = mon[src_bit(k)] & mask_i[src_bit(k)];
  end
endmodule

// File: rtl/intlvl_prio.sv
module intlvl_prio #(
  parameter int NUM_SRC = 13,
  parameter int LVL_W   = 4
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [LVL_W-1:0]   lvl_o
);
  localparam logic [LVL_W-1:0] IDLE_CODE = {LVL_W{1'b1}};

  logic [LVL_W-1:0] code;

  always_comb begin
    code = IDLE_CODE;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pend_i[k]) code = LVL_W'(k);
    end
    lvl_o = code ^ IDLE_CODE;
  end
endmodule

// File: rtl/intlvl_top.sv
module intlvl_top
  import intlvl_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int DATA_W  = WORD_W,
  parameter int LVL_W   = LEVEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [LVL_W-1:0]   lvl_o,
  output logic [DATA_W-1:0]  port_o,
  output logic               off_req_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] mask_q;
  logic [NUM_SRC-1:0] pend;
  logic [LVL_W-1:0]  lvl_d, lvl_q;

  intlvl_decode i_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  intlvl_regs #(.DATA_W(DATA_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .sel_i     (sel),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_q),
    .port_o    (port_o),
    .off_req_o (off_req_o),
    .rd_data_o (rd_data_o)
  );

  intlvl_srcmap #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_srcmap (
    .irq_i  (irq_i),
    .mask_i (mask_q),
    .pend_o (pend)
  );

  intlvl_prio #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_prio (
    .pend_i (pend),
    .lvl_o  (lvl_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_d;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/intlvl_checks.sv
module intlvl_checks
  import intlvl_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int DATA_W  = WORD_W,
  parameter int LVL_W   = LEVEL_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] irq_i,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [LVL_W-1:0]   lvl_o,
  input logic [DATA_W-1:0]  port_o,
  input logic               off_req_o,
  input logic [DATA_W-1:0]  mask_q
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  a_r4_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $stable(irq_i) && $stable(mask_q) |=> $stable(lvl_o));

  a_r3_masked_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q == '0 |=> lvl_o == '0);

  a_r8_off_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_req_o |-> $past(wr_en_i && addr_i == OFS_OFF && wr_data_i[0]));

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  a_r7_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == OFS_VER |=> rd_data_o == DATA_W'(VERSION_ID));

  a_r6_port_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && addr_i == OFS_PORT |=> port_o == $past(wr_data_i));
endmodule

bind intlvl_top intlvl_checks #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .LVL_W   (LVL_W)
) i_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_i),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .lvl_o     (lvl_o),
  .port_o    (port_o),
  .off_req_o (off_req_o),
  .mask_q    (mask_q)
);

// File: tb/test_intlvl_top.sv
module test_intlvl_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] irq = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, port;
  logic [3:0]  lvl;
  logic        off_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  int          bitpos [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
  logic [15:0] m_mask = '0, m_port = '0, m_rdata = '0;
  logic [3:0]  m_lvl = '0;
  logic        m_off = 1'b0;
  string       rd_tag = "R9";

  always #(CLK_PERIOD / 2) clk = ~clk;

  intlvl_top i_intlvl_top (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .irq_i     (irq),
    .wr_en_i   (we),
    .rd_en_i   (re),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .lvl_o     (lvl),
    .port_o    (port),
    .off_req_o (off_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] ref_level(input logic [12:0] lines, input logic [15:0] msk);
    int best = 15;
    for (int k = 12; k >= 0; k--) if (lines[k] && msk[bitpos[k]]) best = k;
    return 4'(best ^ 15);
  endfunction

  function automatic logic [15:0] ref_read(input logic [5:0] a);
    case (a)
      6'h00: return m_mask;
      6'h36: return m_port;
      6'h32: return 16'h0010;
      default: return 16'h0000;
    endcase
  endfunction

  // one clock: inputs set at negedge, model steps at posedge, compare at next negedge
  task automatic step(input logic w, input logic r, input logic [5:0] a,
                      input logic [15:0] d, input logic [12:0] lines, input string tag);
    we = w; re = r; addr = a; wdata = d; irq = lines;
    @(posedge clk);
    m_lvl = ref_level(lines, m_mask);
    if (r) begin m_rdata = ref_read(a); rd_tag = tag; end
    m_off = w && a == 6'h30 && d[0];
    if (w && a == 6'h00) m_mask = d;
    if (w && a == 6'h36) m_port = d;
    @(negedge clk);
    check("R3 level", {12'h0, lvl}, {12'h0, m_lvl});
    check("R6 port", port, m_port);
    check("R8 off_req", {15'h0, off_req}, {15'h0, m_off});
    check(rd_tag, rdata, m_rdata);
    we = 1'b0; re = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [12:0] lines;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lvl", {12'h0, lvl}, 16'h0);
    check("R1 port", port, 16'h0);
    check("R1 off", {15'h0, off_req}, 16'h0);
    check("R1 rdata", rdata, 16'h0);
    irq = '1;
    @(negedge clk);
    check("R1 lvl in reset", {12'h0, lvl}, 16'h0);
    irq = '0;
    rst_ni = 1'b1;
    step(0, 1, 6'h00, 0, '0, "R1 mask read");
    step(0, 1, 6'h36, 0, '0, "R1 port read");

    // R5 mask read-back
    step(1, 0, 6'h00, 16'hA5C3, '0, "R5");
    step(0, 1, 6'h00, 0, '0, "R5 mask readback");
    // R2 / R3 each line alone with full mask
    step(1, 0, 6'h00, 16'hFFFF, '0, "R5");
    for (int k = 0; k < 13; k++) begin
      step(0, 0, 0, 0, 13'(1 << k), "R2");
      check("R2 single line", {12'h0, lvl}, 16'(k ^ 15));
    end
    // R2 each line enabled only by its own mask bit
    for (int k = 0; k < 13; k++) begin
      step(1, 0, 6'h00, 16'(1 << bitpos[k]), '1, "R2");
      step(0, 0, 0, 0, '1, "R2");
      check("R2 own bit", {12'h0, lvl}, 16'(k ^ 15));
    end
    // R2 bits 1..3 enable nothing
    step(1, 0, 6'h00, 16'h000E, '1, "R2");
    step(0, 0, 0, 0, '1, "R2");
    check("R2 unused mask bits", {12'h0, lvl}, 16'h0);
    // R3 several pending, lowest code wins
    step(1, 0, 6'h00, 16'hFFFF, '0, "R3");
    step(0, 0, 0, 0, 13'b1_0011_0000_0000, "R3");
    check("R3 lowest of 8,9,12", {12'h0, lvl}, 16'd7);
    step(0, 0, 0, 0, 13'b1_1110_1000_0000, "R3");
    check("R3 lowest of 7..12", {12'h0, lvl}, 16'd8);

    // R4 mask write and line change in the same cycle
    step(1, 0, 6'h00, 16'h0000, 13'h0001, "R4");
    check("R4 old mask applies", {12'h0, lvl}, 16'd15);
    step(0, 0, 0, 0, 13'h0001, "R4");
    check("R4 new mask applies", {12'h0, lvl}, 16'd0);

    // R10 read and write same register same cycle
    step(1, 1, 6'h00, 16'h1234, '0, "R10 mask old value");
    check("R10 mask pre-write", rdata, 16'h0000);
    step(0, 1, 6'h00, 0, '0, "R10 mask new value");
    step(1, 0, 6'h36, 16'hBEEF, '0, "R6");
    step(1, 1, 6'h36, 16'h0F0F, '0, "R10 port old value");
    check("R10 port pre-write", rdata, 16'hBEEF);
    step(0, 1, 6'h36, 0, '0, "R6 port readback");

    // R7 version
    step(1, 0, 6'h32, 16'hFFFF, '0, "R7");
    step(0, 1, 6'h32, 0, '0, "R7 version");
    check("R7 version value", rdata, 16'h0010);

    // R8 power-off
    step(1, 0, 6'h30, 16'h0001, '0, "R8");
    check("R8 pulse", {15'h0, off_req}, 16'h1);
    step(0, 0, 0, 0, '0, "R8");
    check("R8 single cycle", {15'h0, off_req}, 16'h0);
    step(1, 0, 6'h30, 16'hFFFE, '0, "R8");
    check("R8 bit0 clear", {15'h0, off_req}, 16'h0);
    step(0, 1, 6'h30, 0, '0, "R8 off reads zero");

    // R9 unlisted and odd offsets
    step(1, 0, 6'h01, 16'hFFFF, '0, "R9");
    step(1, 0, 6'h37, 16'hFFFF, '0, "R9");
    step(0, 1, 6'h01, 0, '0, "R9 odd read");
    step(0, 1, 6'h00, 0, '0, "R9 mask untouched");
    check("R9 mask untouched", rdata, 16'h1234);
    step(0, 1, 6'h36, 0, '0, "R9 port untouched");
    step(0, 1, 6'h3E, 0, '0, "R9 unlisted read");

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      lines = 13'($urandom);
      case (op)
        0: step(1, 0, 6'h00, 16'($urandom), lines, "R4");
        1: step(1, 1, 6'h00, 16'($urandom), lines, "R10");
        2: step(1, 0, 6'h36, 16'($urandom), lines, "R6");
        3: step(0, 1, 6'($urandom), 0, lines, "R9");
        4: step(1, 0, 6'($urandom), 16'($urandom), lines, "R9");
        default: step(0, 0, 0, 0, lines, "R3");
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule